// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block sits between a processor bus and three counter channels of a programmable interval timer. It decodes a 2-bit address together with chip select, read and write strobes on an 8-bit data bus. Addresses 0, 1 and 2 reach the counters of channels 0, 1 and 2. Address 3 takes control words, and a read from it returns zero. For every channel the block keeps the counting mode, the decimal (BCD) flag and the byte-access type. It assembles bytes written by the processor into a 16-bit initial count and raises a load strobe for the channel. It hands back the live count, or a frozen snapshot of it, one byte per read.

A control word carries the channel in bits 7:6, the access type in bits 5:4, the mode in bits 3:1 and the BCD flag in bit 0. The channel value 11 is ignored. Access type 00 is a latch command: it snapshots the selected channel's live count without touching its configuration. The other access types are 01 (low byte only), 10 (high byte only) and 11 (low byte, then high byte). The counting logic lives in the channels. This block only supplies their configuration and load strobes, and it reads their live counts.

Each channel has two state machines. The write sequencer has the states WP_LOW and WP_HIGH. In access type 11 a counter write moves WP_LOW to WP_HIGH and WP_HIGH back to WP_LOW, and a mode write forces WP_LOW. The read sequencer has the states RS_LIVE_LO, RS_LIVE_HI, RS_HOLD_LO and RS_HOLD_HI, with these transitions:
- A latch command moves RS_LIVE_LO or RS_LIVE_HI to RS_HOLD_LO and captures the count.
- A read moves RS_LIVE_LO to RS_LIVE_HI, but only in access type 11.
- A read moves RS_LIVE_HI to RS_LIVE_LO.
- A read moves RS_HOLD_LO to RS_HOLD_HI.
- A read moves RS_HOLD_HI to RS_LIVE_LO, which releases the snapshot.
- A latch command in either hold state is ignored.
- A mode write forces RS_LIVE_LO from any state.

Top module: `tmr_bus_if`

## Requirements
- R1: After reset every channel has mode 0, binary counting and access type 11. No load or low-byte strobe is active, and `rdata` is 0 whenever `cs` and `rd` are not both high.
- R2: A write with `cs`=1 to address 3 whose bits 5:4 are not 00 stores mode = bits 3:1, BCD = bit 0 and access = bits 5:4 into the channel named by bits 7:6. The configuration outputs show the new values from the next clock edge on.
- R3: A control word with channel field 11 changes no channel's configuration.
- R4: In access type 01, a counter write sets `init_cnt` to {8'h00, byte} and pulses that channel's `load_stb` for one cycle after the write edge. At most one `load_stb` bit is high at a time.
- R5: In access type 10, a counter write sets `init_cnt` to {byte, 8'h00} and pulses `load_stb` for one cycle.
- R6: In access type 11, the first counter write stores the low byte and pulses `lsb_stb` without `load_stb`. The second write stores the high byte and pulses `load_stb`.
- R7: A mode write returns that channel's write sequencer to the low byte, so a half-finished two-byte load restarts with a low byte.
- R8: Without a pending latch, reads return the live count byte chosen by the access type: the low byte for 01, the high byte for 10, and for 11 the low and high bytes in alternation, starting with the low byte.
- R9: A latch command (bits 5:4 = 00) snapshots the live count. The next two reads return its low byte and then its high byte, whatever the access type and whatever the live count does meanwhile. The channel's mode, BCD and access type stay unchanged.
- R10: The snapshot is released once its high byte has been read, and later reads return the live count again.
- R11: A latch command that arrives while a snapshot is still unread is ignored and does not overwrite the held value.
- R12: A mode write discards a pending snapshot, and the next read returns the live low byte.
- R13: Strobes with `cs`=0 have no effect, and a read from address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, one cycle per byte |
| wr | input | 1 | Write strobe, one cycle per byte |
| addr | input | 2 | Register address (0-2 counters, 3 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle that `cs` and `rd` are high |
| live_cnt | input | 48 | Live count of each channel, 16 bits per channel, channel 0 in the lowest bits |
| load_stb | output | 3 | One-cycle pulse per channel when a complete initial count is ready |
| lsb_stb | output | 3 | One-cycle pulse per channel when the low half of a two-byte count is written |
| init_cnt | output | 48 | Initial count per channel |
| mode_o | output | 9 | Mode per channel, 3 bits each |
| bcd_o | output | 3 | BCD flag per channel |
| acc_o | output | 6 | Access type per channel, 2 bits each |

## Verification
The control word is tried with each access type on a different channel, and with the forbidden channel value, to separate field decoding from channel selection. Counter writes in single-byte low, single-byte high and two-byte order, plus a two-byte load cut short by a mode write, tell apart the zero fill of the missing half, the strobe choice and the sequencer reset. Each channel is given a live count with distinct halves, so a swapped byte shows up at once. Latch tests change the live count after the snapshot, send a second latch before the first has been read, and send a mode write halfway through the read-out. These cases show whether held data, released data and discarded data are each returned correctly.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef enum logic {
        WP_LOW  = 1'b0,
        WP_HIGH = 1'b1
    } wptr_e;

    typedef enum logic [1:0] {
        RS_LIVE_LO = 2'b00,
        RS_LIVE_HI = 2'b01,
        RS_HOLD_LO = 2'b10,
        RS_HOLD_HI = 2'b11
    } rstate_e;

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_bus_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    ctl_we,
    output logic [NCH-1:0]    cnt_we,
    output logic [NCH-1:0]    cnt_re
);

    localparam logic [AW-1:0] CTL_ADDR = AW'(NCH);

    logic ctl_hit;
    assign ctl_hit = cs && wr && (addr == CTL_ADDR);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        // Channel field values that name no channel select nothing.
        assign ctl_we[i] = ctl_hit && (wdata[7:6] == 2'(i));
        assign cnt_we[i] = cs && wr && (addr == AW'(i));
        assign cnt_re[i] = cs && rd && (addr == AW'(i));
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              cnt_we,
    input  logic              cnt_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live,
    output logic              load_stb,
    output logic              lsb_stb,
    output logic [CNT_W-1:0]  init_cnt,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output acc_e              acc,
    output logic [BYTE_W-1:0] rbyte
);

    acc_e             acc_f;
    logic             is_latch;
    logic             is_mode;
    logic             latch_take;
    wptr_e            wstate, wnext;
    rstate_e          rstate, rnext;
    logic [CNT_W-1:0] hold;

    assign acc_f      = acc_e'(wdata[5:4]);
    assign is_latch   = ctl_we && (acc_f == ACC_LATCH);
    assign is_mode    = ctl_we && (acc_f != ACC_LATCH);
    assign latch_take = is_latch && (rstate == RS_LIVE_LO || rstate == RS_LIVE_HI);

    // Configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
            bcd  <= 1'b0;
            acc  <= ACC_LOHI;
        end else if (is_mode) begin
            mode <= wdata[3:1];
            bcd  <= wdata[0];
            acc  <= acc_f;
        end
    end

    // Next state of write sequencer
    always_comb begin
        wnext = wstate;
        if (is_mode) begin
            wnext = WP_LOW;
        end else if (cnt_we && acc == ACC_LOHI) begin
            unique case (wstate)
                WP_LOW:  wnext = WP_HIGH;
                WP_HIGH: wnext = WP_LOW;
            endcase
        end
    end

    // Next state of read sequencer
    always_comb begin
        rnext = rstate;
        if (is_mode) begin
            rnext = RS_LIVE_LO;
        end else begin
            unique case (rstate)
                RS_LIVE_LO: begin
                    if (is_latch)                     rnext = RS_HOLD_LO;
                    else if (cnt_re && acc == ACC_LOHI) rnext = RS_LIVE_HI;
                end
                RS_LIVE_HI: begin
                    if (is_latch)    rnext = RS_HOLD_LO;
                    else if (cnt_re) rnext = RS_LIVE_LO;
                end
                RS_HOLD_LO: if (cnt_re) rnext = RS_HOLD_HI;
                RS_HOLD_HI: if (cnt_re) rnext = RS_LIVE_LO;
            endcase
        end
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wstate <= WP_LOW;
            rstate <= RS_LIVE_LO;
            hold   <= '0;
        end else begin
            wstate <= wnext;
            rstate <= rnext;
            if (latch_take) hold <= live;
        end
    end

    // Registered outputs toward the counting channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt <= '0;
            load_stb <= 1'b0;
            lsb_stb  <= 1'b0;
        end else begin
            load_stb <= 1'b0;
            lsb_stb  <= 1'b0;
            if (cnt_we) begin
                unique case (acc)
                    ACC_LO: begin
                        init_cnt <= {{BYTE_W{1'b0}}, wdata};
                        load_stb <= 1'b1;
                    end
                    ACC_HI: begin
                        init_cnt <= {wdata, {BYTE_W{1'b0}}};
                        load_stb <= 1'b1;
                    end
                    ACC_LOHI: begin
                        if (wstate == WP_LOW) begin
                            init_cnt[BYTE_W-1:0] <= wdata;
                            lsb_stb              <= 1'b1;
                        end else begin
                            init_cnt[CNT_W-1:BYTE_W] <= wdata;
                            load_stb                 <= 1'b1;
                        end
                    end
                    ACC_LATCH: ;
                endcase
            end
        end
    end

    // Read byte selection
    always_comb begin
        unique case (rstate)
            RS_LIVE_LO: rbyte = (acc == ACC_HI) ? live[CNT_W-1:BYTE_W] : live[BYTE_W-1:0];
            RS_LIVE_HI: rbyte = live[CNT_W-1:BYTE_W];
            RS_HOLD_LO: rbyte = hold[BYTE_W-1:0];
            RS_HOLD_HI: rbyte = hold[CNT_W-1:BYTE_W];
        endcase
    end

    // R6
    lsb_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsb_stb |-> acc == ACC_LOHI);

    // R6
    lohi_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && acc == ACC_LOHI) |-> wstate == WP_LOW);

    // R9
    latch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_latch |=> ($stable(mode) && $stable(bcd) && $stable(acc)));

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rstate == RS_HOLD_LO || rstate == RS_HOLD_HI) &&
         ($past(rstate) == RS_HOLD_LO || $past(rstate) == RS_HOLD_HI)) |-> $stable(hold));

    // R12
    mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |=> rstate == RS_LIVE_LO);

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_bus_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic                  cs,
    input  logic                  rd,
    input  logic [AW-1:0]         addr,
    input  logic [NCH*BYTE_W-1:0] rbytes,
    output logic [BYTE_W-1:0]     rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cs && rd && addr == AW'(i)) rdata = rbytes[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
    import tmr_bus_pkg::*;
#(
    parameter  int NCH = 3,
    localparam int AW  = $clog2(NCH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [AW-1:0]         addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [NCH*CNT_W-1:0]  live_cnt,
    output logic [NCH-1:0]        load_stb,
    output logic [NCH-1:0]        lsb_stb,
    output logic [NCH*CNT_W-1:0]  init_cnt,
    output logic [NCH*MODE_W-1:0] mode_o,
    output logic [NCH-1:0]        bcd_o,
    output logic [NCH*2-1:0]      acc_o
);

    logic [NCH-1:0]        ctl_we, cnt_we, cnt_re;
    logic [NCH*BYTE_W-1:0] rbytes;

    tmr_addr_dec #(.NCH(NCH), .AW(AW)) u_dec (
        .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
        .ctl_we(ctl_we), .cnt_we(cnt_we), .cnt_re(cnt_re)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        acc_e acc_i;
        tmr_chan_regs u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctl_we(ctl_we[i]), .cnt_we(cnt_we[i]), .cnt_re(cnt_re[i]),
            .wdata(wdata),
            .live(live_cnt[i*CNT_W +: CNT_W]),
            .load_stb(load_stb[i]), .lsb_stb(lsb_stb[i]),
            .init_cnt(init_cnt[i*CNT_W +: CNT_W]),
            .mode(mode_o[i*MODE_W +: MODE_W]),
            .bcd(bcd_o[i]),
            .acc(acc_i),
            .rbyte(rbytes[i*BYTE_W +: BYTE_W])
        );
        assign acc_o[i*2 +: 2] = acc_i;
    end

    tmr_rd_mux #(.NCH(NCH), .AW(AW)) u_mux (
        .cs(cs), .rd(rd), .addr(addr), .rbytes(rbytes), .rdata(rdata)
    );

    // R4
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    // R1
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> rdata == '0);

endmodule

// File: tb/tmr_bus_if_test.sv
module tmr_bus_if_test;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IN = 2'd2, OP_CF = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  a;
        logic [7:0]  d;
        logic [15:0] e;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 27;
    // WR: e = {lsb_stb, load_stb}; RD: e = rdata; IN: e = init_cnt; CF: e = {mode, bcd, acc}
    localparam vec_t VEC [0:NV-1] = '{
        '{OP_WR, 2'd3, 8'h14, 16'h0000, 4'd2},  // R2 ch0 mode2 low-only
        '{OP_CF, 2'd0, 8'h00, 16'h0011, 4'd2},
        '{OP_WR, 2'd0, 8'h37, 16'h0001, 4'd4},  // R4
        '{OP_IN, 2'd0, 8'h00, 16'h0037, 4'd4},
        '{OP_RD, 2'd0, 8'h00, 16'h0034, 4'd8},  // R8
        '{OP_RD, 2'd0, 8'h00, 16'h0034, 4'd8},
        '{OP_WR, 2'd3, 8'h61, 16'h0000, 4'd2},  // ch1 mode0 bcd high-only
        '{OP_CF, 2'd1, 8'h00, 16'h0006, 4'd2},
        '{OP_WR, 2'd1, 8'h9C, 16'h0002, 4'd5},  // R5
        '{OP_IN, 2'd1, 8'h00, 16'h9C00, 4'd5},
        '{OP_RD, 2'd1, 8'h00, 16'h00AB, 4'd8},
        '{OP_WR, 2'd3, 8'hB6, 16'h0000, 4'd2},  // ch2 mode3 two-byte
        '{OP_CF, 2'd2, 8'h00, 16'h001B, 4'd2},
        '{OP_WR, 2'd2, 8'h10, 16'h0020, 4'd6},  // R6
        '{OP_WR, 2'd2, 8'h27, 16'h0004, 4'd6},
        '{OP_IN, 2'd2, 8'h00, 16'h2710, 4'd6},
        '{OP_RD, 2'd2, 8'h00, 16'h00C3, 4'd8},
        '{OP_RD, 2'd2, 8'h00, 16'h005A, 4'd8},
        '{OP_WR, 2'd3, 8'hF4, 16'h0000, 4'd3},  // R3 forbidden channel
        '{OP_CF, 2'd0, 8'h00, 16'h0011, 4'd3},
        '{OP_CF, 2'd1, 8'h00, 16'h0006, 4'd3},
        '{OP_CF, 2'd2, 8'h00, 16'h001B, 4'd3},
        '{OP_WR, 2'd2, 8'h55, 16'h0020, 4'd7},  // R7
        '{OP_WR, 2'd3, 8'hB6, 16'h0000, 4'd7},
        '{OP_WR, 2'd2, 8'h66, 16'h0020, 4'd7},
        '{OP_WR, 2'd2, 8'h77, 16'h0004, 4'd7},
        '{OP_IN, 2'd2, 8'h00, 16'h7766, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt = {16'h5AC3, 16'hABCD, 16'h1234};
    logic [2:0]  load_stb, lsb_stb, bcd_o;
    logic [47:0] init_cnt;
    logic [8:0]  mode_o;
    logic [5:0]  acc_o;

    int n_run = 0, n_fail = 0;
    logic [5:0] stb_seen;

    always #5 clk = ~clk;

    tmr_bus_if uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .load_stb(load_stb),
        .lsb_stb(lsb_stb), .init_cnt(init_cnt), .mode_o(mode_o), .bcd_o(bcd_o),
        .acc_o(acc_o)
    );

    task automatic check(input int r, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d got %h expected %h", r, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        cs = sel; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        stb_seen = {lsb_stb, load_stb};
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic sel, output logic [7:0] v);
        @(negedge clk);
        cs = sel; rd = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    function automatic logic [15:0] cfg(input int ch);
        return {10'd0, mode_o[ch*3 +: 3], bcd_o[ch], acc_o[ch*2 +: 2]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, cfg(0), 16'h0003);
        check(1, cfg(2), 16'h0003);
        check(1, {10'd0, lsb_stb, load_stb}, 16'h0000);
        check(1, {8'd0, rdata}, 16'h0000);

        for (int k = 0; k < NV; k++) begin
            unique case (VEC[k].op)
                OP_WR: begin
                    bus_wr(VEC[k].a, VEC[k].d, 1'b1);
                    check(int'(VEC[k].r), {10'd0, stb_seen}, VEC[k].e);
                end
                OP_RD: begin
                    bus_rd(VEC[k].a, 1'b1, v);
                    check(int'(VEC[k].r), {8'd0, v}, VEC[k].e);
                end
                OP_IN: check(int'(VEC[k].r), init_cnt[int'(VEC[k].a)*16 +: 16], VEC[k].e);
                OP_CF: check(int'(VEC[k].r), cfg(int'(VEC[k].a)), VEC[k].e);
            endcase
        end

        // R9 latch on channel 2 (two-byte access), live count moves afterwards
        bus_wr(2'd3, 8'h80, 1'b1);
        live_cnt[47:32] = 16'h1111;
        check(9, cfg(2), 16'h001B);
        bus_rd(2'd2, 1'b1, v); check(9, {8'd0, v}, 16'h00C3);
        // R11 second latch while unread is ignored
        live_cnt[47:32] = 16'h2233;
        bus_wr(2'd3, 8'h80, 1'b1);
        bus_rd(2'd2, 1'b1, v); check(11, {8'd0, v}, 16'h005A);
        // R10 released: live again
        bus_rd(2'd2, 1'b1, v); check(10, {8'd0, v}, 16'h0033);
        bus_rd(2'd2, 1'b1, v); check(10, {8'd0, v}, 16'h0022);
        // R12 mode write discards a half-read snapshot
        bus_wr(2'd3, 8'h80, 1'b1);
        live_cnt[47:32] = 16'h4455;
        bus_rd(2'd2, 1'b1, v); check(12, {8'd0, v}, 16'h0033);
        bus_wr(2'd3, 8'hB6, 1'b1);
        bus_rd(2'd2, 1'b1, v); check(12, {8'd0, v}, 16'h0055);
        bus_rd(2'd2, 1'b1, v); check(12, {8'd0, v}, 16'h0044);
        // R9 latch on a low-only channel still yields low then high
        bus_wr(2'd3, 8'h00, 1'b1);
        live_cnt[15:0] = 16'h0000;
        check(9, cfg(0), 16'h0011);
        bus_rd(2'd0, 1'b1, v); check(9, {8'd0, v}, 16'h0034);
        bus_rd(2'd0, 1'b1, v); check(9, {8'd0, v}, 16'h0012);
        bus_rd(2'd0, 1'b1, v); check(10, {8'd0, v}, 16'h0000);
        // R13 deselected strobes and control-address reads
        bus_wr(2'd0, 8'hFF, 1'b0);
        check(13, {10'd0, stb_seen}, 16'h0000);
        check(13, init_cnt[15:0], 16'h0037);
        bus_wr(2'd3, 8'h12, 1'b0);
        check(13, cfg(0), 16'h0011);
        bus_rd(2'd1, 1'b0, v); check(13, {8'd0, v}, 16'h0000);
        bus_rd(2'd3, 1'b1, v); check(13, {8'd0, v}, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule